// File: doc/BRIEF.md
# Power-On Strap Capture and Clock Frequency Select

A small set of package pins does two jobs. While the chip comes out of power-on reset, each pin is an input, and the board ties it high or low with a resistor. Once a timed reset window ends, the block records all five pin levels in a configuration word and then turns the pins into clock outputs. The word never changes after that. The pins can then toggle freely without altering it.

The block decodes the captured word into registered settings for the clock-generation logic that follows it:
- the CPU and PCI target frequencies in kHz;
- the CPU-to-PCI ratio;
- the spread-spectrum setting;
- a flag that makes the dual-mode CPU and SDRAM outputs either free-running or stoppable.

The decoded outputs stay at zero until the word has been captured. A valid flag then rises in the same cycle as the pin output enable.

On the board, the FS1 pin has a pull-down and the other strap pins have pull-ups. An unstrapped part therefore reads FS1 as 0 and every other strap as 1. Frequency synthesis, the PLLs and any serial configuration path are not part of this block.

Top module: `strap_cfg_top`

## Requirements
- R1: From reset until the capture, `pad_oe` is 0 and `pad_out` is all zeros, whatever `clk_src` carries.
- R2: Reset is released before a rising edge. Exactly `POR_CYCLES` rising edges later, `strap_word` takes the value of `pad_in` at that edge. Before that edge, `strap_word` reads 0.
- R3: The strap word has this bit layout: bit0 is FS0, bit1 is FS1, bit2 is the free-run select, and bits 4:3 are spare bits that are stored but not decoded.
- R4: After the capture, changes on `pad_in` have no effect on `strap_word` or on any decoded output until the next reset.
- R5: `pad_oe` and `cfg_valid` rise one cycle after the capture. From then on, `pad_out` equals `clk_src` bit for bit.
- R6: Once valid, the frequency code {FS1,FS0} sets CPU/PCI in kHz as follows:
  - 00 gives 66666/33333
  - 01 gives 100000/33333
  - 10 gives 97000/32333
  - 11 gives 133333/33333
- R7: Once valid, `pci_ratio` is the CPU/PCI frequency ratio rounded to the nearest integer. For codes 00, 01, 10 and 11 it is 2, 3, 3 and 4.
- R8: Once valid, `spread_en` is 1 and `spread_ppm` is 5000 (0.5 % down-spread) for every frequency code.
- R9: Once valid, `stoppable` equals strap bit2: 0 means free-running and 1 means stoppable.
- R10: Until `cfg_valid` rises, all decoded outputs (`cpu_khz`, `pci_khz`, `pci_ratio`, `spread_en`, `spread_ppm`, `stoppable`) are 0.
- R11: Once `cfg_valid` is 1, it stays 1 until reset. Asserting `rst_n` clears the configuration at once and restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pad_in | input | 5 | Levels sensed on the shared pins |
| clk_src | input | 5 | Buffered clocks to drive onto the pins after the window |
| pad_out | output | 5 | Pin output data |
| pad_oe | output | 1 | Pin driver enable |
| strap_word | output | 5 | Captured configuration word |
| cpu_khz | output | 18 | CPU target frequency in kHz |
| pci_khz | output | 18 | PCI target frequency in kHz |
| pci_ratio | output | 3 | Rounded CPU/PCI ratio |
| spread_en | output | 1 | Spread-spectrum enable |
| spread_ppm | output | 13 | Down-spread depth in ppm |
| stoppable | output | 1 | 1 means dual-mode outputs may be stopped |
| cfg_valid | output | 1 | Configuration captured and decoded |

## Verification
A window counter that runs one cycle off shows up directly at the ports. `strap_word` then takes on a level one edge early or late, and `pad_oe` rises in the wrong cycle. Both are seen on the first cycle around the expected capture.

A capture register that still listens to the pins, or a decode that skips its gate, shows within one cycle of a pin change or of the capture. It appears as a moved `strap_word`, as nonzero settings before `cfg_valid`, or as a wrong kHz or ratio for a strap pattern.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int KHZ_W   = 18;
  localparam int RATIO_W = 3;
  localparam int PPM_W   = 13;
  localparam int DOWN_SPREAD_PPM = 5000;

  function automatic logic [KHZ_W-1:0] cpu_khz_of(input logic [1:0] fs);
    case (fs)
      2'b00:   return KHZ_W'(66666);
      2'b01:   return KHZ_W'(100000);
      2'b10:   return KHZ_W'(97000);
      default: return KHZ_W'(133333);
    endcase
  endfunction

  function automatic logic [KHZ_W-1:0] pci_khz_of(input logic [1:0] fs);
    return (fs == 2'b10) ? KHZ_W'(32333) : KHZ_W'(33333);
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [1:0] fs);
    logic [KHZ_W-1:0] c, p;
    c = cpu_khz_of(fs);
    p = pci_khz_of(fs);
    return RATIO_W'((c + (p >> 1)) / p);
  endfunction
endpackage

// File: rtl/por_window.sv
module por_window #(
  parameter int POR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic latch_stb,
  output logic drive_en
);
  localparam int CW = (POR_CYCLES > 2) ? $clog2(POR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign latch_stb = !done_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      done_q   <= 1'b0;
      drive_en <= 1'b0;
    end else begin
      if (!done_q && !latch_stb) cnt_q <= cnt_q + 1'b1;
      if (latch_stb) done_q <= 1'b1;
      drive_en <= done_q;
    end
  end

  assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> !latch_stb);
  assert_oe_after_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> done_q && !latch_stb);
  assert_oe_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |=> drive_en);
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int NPINS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_stb,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] word_q,
  output logic             loaded_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      loaded_q <= 1'b0;
    end else if (latch_stb && !loaded_q) begin
      word_q   <= pad_in;
      loaded_q <= 1'b1;
    end
  end

  assert_word_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && $past(loaded_q)) |-> $stable(word_q));
  assert_load_on_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded_q) |-> $past(latch_stb));
endmodule

// File: rtl/freq_decode.sv
module freq_decode
  import strap_cfg_pkg::*;
#(
  parameter int NPINS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loaded,
  input  logic [NPINS-1:0]   word,
  output logic [KHZ_W-1:0]   cpu_khz,
  output logic [KHZ_W-1:0]   pci_khz,
  output logic [RATIO_W-1:0] pci_ratio,
  output logic               spread_en,
  output logic [PPM_W-1:0]   spread_ppm,
  output logic               stoppable
);
  logic [1:0] fs;
  assign fs = word[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_khz    <= '0;
      pci_khz    <= '0;
      pci_ratio  <= '0;
      spread_en  <= 1'b0;
      spread_ppm <= '0;
      stoppable  <= 1'b0;
    end else if (loaded) begin
      cpu_khz    <= cpu_khz_of(fs);
      pci_khz    <= pci_khz_of(fs);
      pci_ratio  <= ratio_of(fs);
      spread_en  <= 1'b1;
      spread_ppm <= PPM_W'(DOWN_SPREAD_PPM);
      stoppable  <= word[2];
    end
  end

  assert_cpu_above_pci_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spread_en |-> (cpu_khz > pci_khz));
  assert_ratio_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spread_en |-> (pci_ratio >= 3'd2 && pci_ratio <= 3'd4));
  assert_spread_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spread_en |-> (spread_ppm == PPM_W'(DOWN_SPREAD_PPM)));
endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
  import strap_cfg_pkg::*;
#(
  parameter int POR_CYCLES = 16,
  parameter int NPINS      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pad_in,
  input  logic [NPINS-1:0]   clk_src,
  output logic [NPINS-1:0]   pad_out,
  output logic               pad_oe,
  output logic [NPINS-1:0]   strap_word,
  output logic [KHZ_W-1:0]   cpu_khz,
  output logic [KHZ_W-1:0]   pci_khz,
  output logic [RATIO_W-1:0] pci_ratio,
  output logic               spread_en,
  output logic [PPM_W-1:0]   spread_ppm,
  output logic               stoppable,
  output logic               cfg_valid
);
  logic latch_stb;
  logic drive_en;
  logic loaded;

  por_window #(.POR_CYCLES(POR_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .latch_stb(latch_stb), .drive_en(drive_en)
  );

  strap_latch #(.NPINS(NPINS)) u_latch (
    .clk(clk), .rst_n(rst_n), .latch_stb(latch_stb), .pad_in(pad_in),
    .word_q(strap_word), .loaded_q(loaded)
  );

  freq_decode #(.NPINS(NPINS)) u_dec (
    .clk(clk), .rst_n(rst_n), .loaded(loaded), .word(strap_word),
    .cpu_khz(cpu_khz), .pci_khz(pci_khz), .pci_ratio(pci_ratio),
    .spread_en(spread_en), .spread_ppm(spread_ppm), .stoppable(stoppable)
  );

  assign pad_oe    = drive_en;
  assign cfg_valid = drive_en;
  assign pad_out   = drive_en ? clk_src : '0;

  assert_no_drive_before_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !drive_en);
  assert_decode_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spread_en == drive_en);
endmodule

// File: tb/strap_cfg_top_test.sv
module strap_cfg_top_test;
  localparam int POR = 16;
  localparam int NV  = 8;
  localparam logic [4:0] VEC_WORD [NV] = '{5'b00000, 5'b00001, 5'b00010, 5'b00011,
                                           5'b00100, 5'b11111, 5'b10110, 5'b01001};
  localparam int EXP_CPU [4] = '{66666, 100000, 97000, 133333};
  localparam int EXP_PCI [4] = '{33333, 33333, 32333, 33333};
  localparam int EXP_RAT [4] = '{2, 3, 3, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] pad_in = '0;
  logic [4:0] clk_src = '0;
  logic [4:0] pad_out, strap_word;
  logic pad_oe, spread_en, stoppable, cfg_valid;
  logic [17:0] cpu_khz, pci_khz;
  logic [2:0] pci_ratio;
  logic [12:0] spread_ppm;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  strap_cfg_top #(.POR_CYCLES(POR)) uut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .clk_src(clk_src),
    .pad_out(pad_out), .pad_oe(pad_oe), .strap_word(strap_word),
    .cpu_khz(cpu_khz), .pci_khz(pci_khz), .pci_ratio(pci_ratio),
    .spread_en(spread_en), .spread_ppm(spread_ppm), .stoppable(stoppable),
    .cfg_valid(cfg_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_idle_decode(input string req);
    chk(req, cpu_khz, 0);
    chk(req, pci_khz, 0);
    chk(req, pci_ratio, 0);
    chk(req, spread_en, 0);
    chk(req, spread_ppm, 0);
    chk(req, stoppable, 0);
  endtask

  task automatic restart();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset oe", pad_oe, 0);
    chk("R11 reset valid", cfg_valid, 0);
    chk("R2 reset word", strap_word, 0);
    chk_idle_decode("R10 reset");

    for (int i = 0; i < NV; i++) begin
      logic [4:0] w;
      logic [1:0] fs;
      w = VEC_WORD[i];
      fs = w[1:0];
      pad_in = w;
      clk_src = 5'b11111;
      restart();
      repeat (POR - 1) @(negedge clk);
      chk("R1 window oe", pad_oe, 0);
      chk("R1 window pads", pad_out, 0);
      chk("R2 word before capture", strap_word, 0);
      chk_idle_decode("R10 before capture");
      @(negedge clk);
      chk("R2 R3 captured word", strap_word, w);
      chk("R5 oe not yet", pad_oe, 0);
      chk("R10 still idle", spread_en, 0);
      pad_in = ~w;
      @(negedge clk);
      chk("R5 oe", pad_oe, 1);
      chk("R11 valid", cfg_valid, 1);
      chk("R5 pads follow", pad_out, 5'b11111);
      chk("R4 word held", strap_word, w);
      chk("R6 cpu", cpu_khz, EXP_CPU[fs]);
      chk("R6 pci", pci_khz, EXP_PCI[fs]);
      chk("R7 ratio", pci_ratio, EXP_RAT[fs]);
      chk("R8 spread", spread_en, 1);
      chk("R8 ppm", spread_ppm, 5000);
      chk("R9 stoppable", stoppable, w[2]);
      clk_src = 5'b01010;
      pad_in = 5'b10101;
      repeat (5) @(negedge clk);
      chk("R5 pads follow 2", pad_out, 5'b01010);
      chk("R4 word still held", strap_word, w);
      chk("R4 cpu held", cpu_khz, EXP_CPU[fs]);
      chk("R11 valid sticky", cfg_valid, 1);
    end

    // R11: reset mid-operation clears everything at once
    #1 rst_n = 1'b0;
    #1;
    chk("R11 async clear", cfg_valid, 0);
    chk("R1 async pads", pad_out, 0);
    chk_idle_decode("R10 after reset");
    @(negedge clk);
    rst_n = 1'b1;
    pad_in = 5'b00011;
    repeat (POR - 1) @(negedge clk);
    chk("R11 restart window", pad_oe, 0);
    repeat (2) @(negedge clk);
    chk("R11 restart valid", cfg_valid, 1);
    chk("R6 restart cpu", cpu_khz, 133333);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule